// File: doc/BRIEF.md
# Pause-Loop Spin Detector

This block watches the pause events a virtualized core retires and decides when a guest has been spinning in a pause loop for too long. Time is kept by a free-running timestamp count inside the block. The count advances only on cycles where the tick enable input is high, so it runs at the timestamp rate and not at the core clock rate. Software supplies two 32-bit limits. The gap limit decides whether a new pause still belongs to the running loop or opens a fresh one. The window limit bounds how long one loop may last before the block asks for an exit.

The detector is a three-state machine:
- **IDLE**: no loop is being tracked.
- **LOOP**: a loop is open, and the block holds the timestamp of its first pause and of its most recent pause.
- **HOLD**: an exit has been requested, and the block waits for the acknowledge.

The transitions are:
- **open** (IDLE to LOOP): any pause.
- **restart** (LOOP to LOOP): a pause after too long a gap; both marks reload.
- **extend** (LOOP to LOOP): a pause inside the gap while the window still holds; only the last mark reloads.
- **trip** (LOOP to HOLD): a pause inside the gap once the window is exceeded; this fires the exit request.
- **release** (HOLD to IDLE): the exit acknowledge.
- **drop** (any state to IDLE): the enable input is low.

Reset also returns the machine to IDLE.

Top module: `pause_spin_detector`

## Requirements
- R1: After a synchronous reset, `exit_req` is 0, the machine is in IDLE and the timestamp count is 0.
- R2: While in LOOP, a pause whose timestamp distance from the previous pause is strictly greater than `gap_limit` opens a new loop whose start is that pause. A distance equal to `gap_limit` continues the current loop.
- R3: While in LOOP, a pause that continues the loop and lies strictly more than `window_limit` ticks after the loop's first pause raises `exit_req`. The request is high for exactly one clock, in the cycle after the one in which that pause is sampled.
- R4: A continuing pause exactly `window_limit` ticks after the loop start raises no request.
- R5: While `enable` is 0, no exit request is produced, and pauses have no effect.
- R6: After an exit request, pauses are ignored until `exit_ack` is seen. `exit_ack` has no effect outside that waiting state. The first pause after the acknowledge opens a new loop.
- R7: The first pause after a reset, or after `enable` returns from 0, opens a new loop and cannot cause an exit by itself. Reset or a low `enable` in the middle of a loop discards that loop.
- R8: The timestamp count advances by one only in cycles where `tick` is 1. Clock cycles without a tick add no elapsed time.
- R9: Elapsed times are unsigned differences taken modulo 2^TS_W (`TS_W` is the width of the timestamp count), so a loop that straddles a wrap of the count is timed correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Pause-loop exiting control; 0 disables and clears the detector |
| gap_limit | input | 32 | Largest tick distance between two pauses of one loop |
| window_limit | input | 32 | Largest tick span of one loop before an exit is requested |
| tick | input | 1 | Timestamp-rate enable; the count advances when high |
| pause | input | 1 | One-cycle pulse per retired pause |
| exit_ack | input | 1 | Acknowledge of a previous exit request |
| exit_req | output | 1 | One-cycle exit request |

## Verification
The hardest situation to reach from the ports is a loop that straddles the wrap of the timestamp count. With the default 64-bit count, that wrap can never be reached. The bench therefore builds the block with a 12-bit count and keeps the tick running. It waits until the count sits a few ticks before its wrap, then opens a loop whose later pauses fall after the wrap. It checks that the gap comparison and the window comparison both still give the right answers. The boundary cases are driven with exact pause spacing, so the elapsed time lands exactly on each limit and then one tick beyond it: a gap equal to the limit versus one tick over, and a window equal to the limit versus one tick over.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_HOLD = 2'd2
    } loop_state_e;

    localparam int LIMIT_W = 32;

endpackage

// File: rtl/psd_timebase.sv
`timescale 1ns/1ps
module psd_timebase #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    output logic [TS_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (tick) begin
            now <= now + TS_W'(1);
        end
    end

endmodule

// File: rtl/psd_elapsed.sv
`timescale 1ns/1ps
module psd_elapsed #(
    parameter int TS_W  = 64,
    parameter int LIM_W = 32
) (
    input  logic [TS_W-1:0]  now,
    input  logic [TS_W-1:0]  mark,
    input  logic [LIM_W-1:0] limit,
    output logic             over
);

    localparam int CMP_W = (TS_W > LIM_W) ? TS_W : LIM_W;

    logic [TS_W-1:0]  span;
    logic [CMP_W-1:0] span_x;
    logic [CMP_W-1:0] limit_x;

    // Modulo 2^TS_W distance: wrap of the count cancels out.
    assign span    = now - mark;
    assign span_x  = CMP_W'(span);
    assign limit_x = CMP_W'(limit);
    assign over    = span_x > limit_x;

endmodule

// File: rtl/psd_loop_fsm.sv
`timescale 1ns/1ps
module psd_loop_fsm
    import psd_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            pause,
    input  logic            exit_ack,
    input  logic            gap_over,
    input  logic            win_over,
    input  logic [TS_W-1:0] now,
    output logic [TS_W-1:0] start_mark,
    output logic [TS_W-1:0] last_mark,
    output logic            exit_req,
    output loop_state_e     state_o
);

    loop_state_e state;
    loop_state_e state_nxt;
    logic        load_start;
    logic        load_last;
    logic        fire;

    always_comb begin
        state_nxt  = state;
        load_start = 1'b0;
        load_last  = 1'b0;
        fire       = 1'b0;
        if (!enable) begin
            state_nxt = ST_IDLE;                      // drop
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pause) begin                  // open
                        state_nxt  = ST_LOOP;
                        load_start = 1'b1;
                        load_last  = 1'b1;
                    end
                end
                ST_LOOP: begin
                    if (pause) begin
                        if (gap_over) begin           // restart
                            load_start = 1'b1;
                            load_last  = 1'b1;
                        end else if (win_over) begin  // trip
                            state_nxt = ST_HOLD;
                            fire      = 1'b1;
                        end else begin                // extend
                            load_last = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (exit_ack) begin               // release
                        state_nxt = ST_IDLE;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Timestamp marks of the open loop
    always_ff @(posedge clk) begin
        if (rst) begin
            start_mark <= '0;
            last_mark  <= '0;
        end else begin
            if (load_start) start_mark <= now;
            if (load_last)  last_mark  <= now;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            exit_req <= 1'b0;
        end else begin
            exit_req <= fire;
        end
    end

    assign state_o = state;

endmodule

// File: rtl/pause_spin_detector.sv
`timescale 1ns/1ps
module pause_spin_detector
    import psd_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [LIMIT_W-1:0] gap_limit,
    input  logic [LIMIT_W-1:0] window_limit,
    input  logic               tick,
    input  logic               pause,
    input  logic               exit_ack,
    output logic               exit_req
);

    logic [TS_W-1:0] now;
    logic [TS_W-1:0] start_mark;
    logic [TS_W-1:0] last_mark;
    logic            gap_over;
    logic            win_over;
    loop_state_e     loop_state;

    psd_timebase #(.TS_W(TS_W)) u_timebase (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .now  (now)
    );

    psd_elapsed #(.TS_W(TS_W), .LIM_W(LIMIT_W)) u_gap_cmp (
        .now   (now),
        .mark  (last_mark),
        .limit (gap_limit),
        .over  (gap_over)
    );

    psd_elapsed #(.TS_W(TS_W), .LIM_W(LIMIT_W)) u_win_cmp (
        .now   (now),
        .mark  (start_mark),
        .limit (window_limit),
        .over  (win_over)
    );

    psd_loop_fsm #(.TS_W(TS_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .pause      (pause),
        .exit_ack   (exit_ack),
        .gap_over   (gap_over),
        .win_over   (win_over),
        .now        (now),
        .start_mark (start_mark),
        .last_mark  (last_mark),
        .exit_req   (exit_req),
        .state_o    (loop_state)
    );

endmodule

// File: rtl/psd_checks.sv
`timescale 1ns/1ps
module psd_checks
    import psd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        pause,
    input logic        exit_ack,
    input logic        exit_req,
    input loop_state_e state
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!exit_req && state == ST_IDLE));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        exit_req |=> !exit_req);

    p_exit_cause_r3: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> ($past(pause) && $past(enable)));

    p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!exit_req && state == ST_IDLE));

    p_exit_waits_r6: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> state == ST_HOLD);

    p_hold_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |=> !exit_req);

    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && enable && !exit_ack) |=> state == ST_HOLD);

    p_first_pause_safe_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> !exit_req);

endmodule

bind pause_spin_detector psd_checks u_checks (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .pause    (pause),
    .exit_ack (exit_ack),
    .exit_req (exit_req),
    .state    (loop_state)
);

// File: tb/test_pause_spin_detector.sv
`timescale 1ns/1ps
module test_pause_spin_detector;

    localparam int  TS_W = 12;
    localparam longint MASK = (64'd1 << TS_W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [31:0] gap_limit = 32'd0;
    logic [31:0] window_limit = 32'd0;
    logic        tick = 1'b1;
    logic        pause = 1'b0;
    logic        exit_ack = 1'b0;
    logic        exit_req;

    int     errors = 0;
    int     checks = 0;
    int     exit_cnt = 0;
    int     base = 0;
    string  cur_req = "R1";

    // Behavioural reference model
    longint m_ts = 0;
    longint m_start = 0;
    longint m_last = 0;
    bit     m_active = 0;
    bit     m_hold = 0;
    bit     m_exit = 0;

    always #5 clk = ~clk;

    pause_spin_detector #(.TS_W(TS_W)) i_pause_spin_detector (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .gap_limit    (gap_limit),
        .window_limit (window_limit),
        .tick         (tick),
        .pause        (pause),
        .exit_ack     (exit_ack),
        .exit_req     (exit_req)
    );

    always @(posedge clk) begin
        bit nexit;
        nexit = 0;
        if (rst) begin
            m_ts = 0; m_active = 0; m_hold = 0; m_exit = 0;
            m_start = 0; m_last = 0;
        end else begin
            if (!enable) begin
                m_active = 0; m_hold = 0;
            end else if (m_hold) begin
                if (exit_ack) m_hold = 0;
            end else if (pause) begin
                if (!m_active || (((m_ts - m_last) & MASK) > longint'(gap_limit))) begin
                    m_active = 1; m_start = m_ts; m_last = m_ts;
                end else if (((m_ts - m_start) & MASK) > longint'(window_limit)) begin
                    nexit = 1; m_active = 0; m_hold = 1;
                end else begin
                    m_last = m_ts;
                end
            end
            m_exit = nexit;
            if (tick) m_ts = (m_ts + 1) & MASK;
        end
    end

    // Every-cycle comparison against the model, plus pulse counting
    always @(negedge clk) begin
        checks++;
        if (exit_req !== m_exit) begin
            errors++;
            $display("FAIL %s cycle compare: exit_req actual=%b expected=%b at %0t",
                     cur_req, exit_req, m_exit, $time);
        end
        if (exit_req === 1'b1) exit_cnt++;
    end

    task automatic gp(input int d, input bit ack = 0);
        for (int i = 0; i < d - 1; i++) @(negedge clk);
        pause = 1'b1;
        exit_ack = ack;
        @(negedge clk);
        pause = 1'b0;
        exit_ack = 1'b0;
    endtask

    task automatic check_cnt(input int exp, input string req);
        @(negedge clk);
        #1;
        checks++;
        if (exit_cnt - base != exp) begin
            errors++;
            $display("FAIL %s exit count actual=%0d expected=%0d", req, exit_cnt - base, exp);
        end
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        exit_ack = 1'b1;
        @(negedge clk);
        exit_ack = 1'b0;
    endtask

    task automatic clear_loop();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        base = exit_cnt;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (exit_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset exit_req actual=%b expected=0", exit_req);
        end
        @(negedge clk);
        rst = 1'b0;
        enable = 1'b1;

        // R4 and R3: window boundary; an ack mid-loop has no effect (R6)
        cur_req = "R4";
        gap_limit = 32'd10; window_limit = 32'd12;
        base = exit_cnt;
        gp(1);
        gp(4, 1'b1);
        gp(4); gp(4);
        check_cnt(0, "R4");
        cur_req = "R3";
        gp(3);
        check_cnt(1, "R3");

        // R6: pauses ignored while waiting for ack
        cur_req = "R6";
        base = exit_cnt;
        for (int i = 0; i < 20; i++) gp(1);
        check_cnt(0, "R6");
        ack_pulse();
        base = exit_cnt;
        for (int i = 0; i < 13; i++) gp(1);
        check_cnt(0, "R6");
        gp(1);
        check_cnt(1, "R6");
        ack_pulse();

        // R2: gap equal continues, one over restarts
        cur_req = "R2";
        gap_limit = 32'd5; window_limit = 32'd8;
        clear_loop();
        gp(1); gp(5); gp(5);
        check_cnt(1, "R2");
        ack_pulse();
        clear_loop();
        gp(1); gp(6); gp(5);
        check_cnt(0, "R2");

        // R5: disabled
        cur_req = "R5";
        @(negedge clk);
        enable = 1'b0;
        base = exit_cnt;
        for (int i = 0; i < 40; i++) gp(1);
        check_cnt(0, "R5");
        enable = 1'b1;

        // R7: enable drop mid-loop discards it
        cur_req = "R7";
        gap_limit = 32'd10; window_limit = 32'd12;
        base = exit_cnt;
        gp(1); gp(4); gp(4); gp(4);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        gp(2);
        check_cnt(0, "R7");
        // R7: reset mid-loop discards it
        clear_loop();
        gp(1); gp(4); gp(4); gp(4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        gp(2);
        check_cnt(0, "R7");

        // R8: no tick, no time
        cur_req = "R8";
        gap_limit = 32'd5; window_limit = 32'd3;
        clear_loop();
        tick = 1'b0;
        gp(1);
        for (int i = 0; i < 10; i++) gp(2);
        check_cnt(0, "R8");
        tick = 1'b1;
        gp(2); gp(2); gp(2);
        check_cnt(1, "R8");
        ack_pulse();

        // R9: loop across the wrap of the count
        cur_req = "R9";
        gap_limit = 32'd5; window_limit = 32'd10;
        clear_loop();
        while (m_ts != 4088) @(negedge clk);
        pause = 1'b1;
        @(negedge clk);
        pause = 1'b0;
        gp(3); gp(3); gp(3);
        check_cnt(0, "R9");
        gp(2);
        check_cnt(1, "R9");
        ack_pulse();

        repeat (4) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule